// File: doc/BRIEF.md
# Register-Programmed Pulse-Width Modulator

This block is a single-channel pulse-width modulator that software controls through a small word-wide register port. A prescaler divides the source clock by one plus a scale value and produces a tick. A period counter advances on each tick and wraps after depth-plus-one counts. The output is high while the count is below the programmed duty value. When the block is disabled, the output is held low and both counters are held at zero.

A build parameter selects one of two register layouts:

- **Compact layout.** A single register holds the enable bit, an 8-bit duty field, a force-full bit and a 13-bit scale. The period depth is fixed at 256 counts.
- **Wide layout.** Register 0 holds a 16-bit duty and a 16-bit scale. Register 1 holds the enable bit and a 16-bit depth value.

Duty, scale and depth writes made while the block runs are buffered. They take effect only at the next period boundary, so a period is never cut short or stretched partway through.

Top module: `pwm_top`

## Requirements
- R1: After reset the output is low, and every register reads as zero.
- R2: Compact layout (WIDE_LAYOUT=0), register 0 at byte address 0:
  - Bit 31 is the enable bit.
  - Bit 24 is force-full.
  - Bits 23:16 are duty.
  - Bits 12:0 are scale.
  - Writing all ones reads back 0x81FF_1FFF.
  - Byte address 4 holds nothing and reads 0.
- R3: Wide layout (WIDE_LAYOUT=1):
  - Register 0 holds duty in bits 31:16 and scale in bits 15:0. It reads back every bit written.
  - Register 1, at byte address 4, holds the enable bit in bit 31 and depth in bits 30:15. Writing all ones reads back 0xFFFF_8000.
  - Any other address reads 0.
- R4: While running, each period lasts (depth+1)·(scale+1) clock cycles, with depth fixed at 255 in the compact layout. The output is high for the first duty·(scale+1) cycles of each period.
- R5: A duty value of 0 keeps the output low for the whole period.
- R6: In the compact layout, setting bit 24 keeps the output high for the whole period, whatever bits 23:16 hold.
- R7: In the wide layout, a duty value of depth+1 or more keeps the output high for the whole period.
- R8: Disabling the block drives the output low by the second clock edge after the write. Enabling restarts both counters at zero, and the output shows the first count of the new period one edge after the enable bit is stored.
- R9: Duty, scale and depth writes made while the block runs take effect only at the next period boundary.
- R10: A read returns the selected register on `rdata` one clock edge after `rd_en` is sampled. `rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address; bits 1:0 must be zero for a register to match |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Registered modulated output, high when active |

## Verification
Each result has a fixed due cycle after its stimulus:

- **Register write.** The value is stored at the sampling edge.
- **Enable.** The core starts on the following edge, so the output reflects count zero two edges after the write strobe is sampled.
- **Disable.** The output goes low on the same second edge.
- **Read.** Data appears one edge after the strobe.

Every bench task drives inputs on falling edges and samples on falling edges. Each task waits exactly the number of edges listed above before its first sample. High time is then counted over windows whose length is the period formula. The mid-period update check writes at a known phase and counts the highs left in that period separately from those in the following period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W       = 16;
  localparam int DUTY_W      = CNT_W + 1;
  localparam int LEG_DUTY_W  = 8;
  localparam int LEG_SCALE_W = 13;
  localparam int LEG_DEPTH   = 255;

  localparam logic [31:0] LEG_R0_MASK  = 32'h81FF_1FFF;
  localparam logic [31:0] LEG_R1_MASK  = 32'h0000_0000;
  localparam logic [31:0] WIDE_R0_MASK = 32'hFFFF_FFFF;
  localparam logic [31:0] WIDE_R1_MASK = 32'hFFFF_8000;

  typedef struct packed {
    logic              en;
    logic [DUTY_W-1:0] duty;
    logic [CNT_W-1:0]  scale;
    logic [CNT_W-1:0]  depth;
  } cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter bit WIDE_LAYOUT = 1'b0,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output cfg_t              cfg
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [31:0] MASK0 = WIDE_LAYOUT ? WIDE_R0_MASK : LEG_R0_MASK;
  localparam logic [31:0] MASK1 = WIDE_LAYOUT ? WIDE_R1_MASK : LEG_R1_MASK;

  logic [31:0]      r0_q, r1_q;
  logic             aligned, hit0, hit1;
  logic [IDX_W-1:0] idx;

  assign aligned = (addr[1:0] == 2'b00);
  assign idx     = addr[ADDR_W-1:2];
  assign hit0    = aligned && (idx == IDX_W'(0));
  assign hit1    = aligned && (idx == IDX_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      r0_q <= '0;
      r1_q <= '0;
    end else if (wr_en) begin
      if (hit0) r0_q <= wdata & MASK0;
      if (hit1) r1_q <= wdata & MASK1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= hit0 ? r0_q : (hit1 ? r1_q : 32'h0);
  end

  generate
    if (WIDE_LAYOUT) begin : g_wide
      assign cfg.en    = r1_q[31];
      assign cfg.duty  = DUTY_W'(r0_q[31:16]);
      assign cfg.scale = r0_q[15:0];
      assign cfg.depth = r1_q[30:15];
    end else begin : g_compact
      assign cfg.en    = r0_q[31];
      assign cfg.duty  = r0_q[24] ? DUTY_W'(LEG_DEPTH + 1)
                                  : DUTY_W'(r0_q[16 +: LEG_DUTY_W]);
      assign cfg.scale = CNT_W'(r0_q[LEG_SCALE_W-1:0]);
      assign cfg.depth = CNT_W'(LEG_DEPTH);
    end
  endgenerate
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/pwm_period.sv
module pwm_period
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cfg_t              cfg,
  input  logic              tick,
  output logic              pwm_out,
  output logic              running,
  output logic [CNT_W-1:0]  per_cnt,
  output logic [DUTY_W-1:0] duty_s,
  output logic [CNT_W-1:0]  depth_s,
  output logic [CNT_W-1:0]  scale_s
);
  logic [DUTY_W-1:0] per_nx;
  logic              at_end;

  assign per_nx = DUTY_W'(per_cnt) + DUTY_W'(1);
  assign at_end = (per_cnt == depth_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      per_cnt <= '0;
      pwm_out <= 1'b0;
      duty_s  <= '0;
      depth_s <= '0;
      scale_s <= '0;
    end else if (!cfg.en) begin
      running <= 1'b0;
      per_cnt <= '0;
      pwm_out <= 1'b0;
    end else if (!running || (tick && at_end)) begin
      // start or period boundary: take new settings, begin at count zero
      running <= 1'b1;
      per_cnt <= '0;
      duty_s  <= cfg.duty;
      depth_s <= cfg.depth;
      scale_s <= cfg.scale;
      pwm_out <= (cfg.duty != '0);
    end else if (tick) begin
      per_cnt <= per_nx[CNT_W-1:0];
      pwm_out <= (per_nx < duty_s);
    end
  end
endmodule

// File: rtl/pwm_top.sv
module pwm_top
  import pwm_pkg::*;
#(
  parameter bit WIDE_LAYOUT = 1'b0,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              pwm_out
);
  cfg_t              cfg;
  logic              tick, running;
  logic [CNT_W-1:0]  per_cnt, depth_s, scale_s;
  logic [DUTY_W-1:0] duty_s;

  pwm_regfile #(.WIDE_LAYOUT(WIDE_LAYOUT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cfg(cfg)
  );

  pwm_prescale #(.W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .clr(!running), .limit(scale_s), .tick(tick)
  );

  pwm_period u_core (
    .clk(clk), .rst(rst), .cfg(cfg), .tick(tick), .pwm_out(pwm_out),
    .running(running), .per_cnt(per_cnt), .duty_s(duty_s),
    .depth_s(depth_s), .scale_s(scale_s)
  );
endmodule

// File: rtl/pwm_chk.sv
module pwm_chk
  import pwm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              pwm_out,
  input logic              running,
  input logic [CNT_W-1:0]  per_cnt,
  input logic [DUTY_W-1:0] duty_s,
  input logic [CNT_W-1:0]  depth_s
);
  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);

  // R8
  off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (per_cnt == '0) && !running);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> per_cnt <= depth_s);

  // R4
  out_track_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> pwm_out == (DUTY_W'(per_cnt) < duty_s));

  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (running && duty_s == '0) |-> !pwm_out);

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (per_cnt != '0) |-> ($stable(duty_s) && $stable(depth_s)));
endmodule

bind pwm_top pwm_chk u_chk (
  .clk(clk), .rst(rst), .en(cfg.en), .pwm_out(pwm_out), .running(running),
  .per_cnt(per_cnt), .duty_s(duty_s), .depth_s(depth_s)
);

// File: tb/tb_pwm_top.sv
module tb_pwm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_l = 1'b0, wr_w = 1'b0, rd_l = 1'b0, rd_w = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_l, rdata_w;
  logic        out_l, out_w;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  pwm_top #(.WIDE_LAYOUT(1'b0), .ADDR_W(4)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_l), .rd_en(rd_l), .addr(addr),
    .wdata(wdata), .rdata(rdata_l), .pwm_out(out_l)
  );

  pwm_top #(.WIDE_LAYOUT(1'b1), .ADDR_W(4)) dut_wide (
    .clk(clk), .rst(rst), .wr_en(wr_w), .rd_en(rd_w), .addr(addr),
    .wdata(wdata), .rdata(rdata_w), .pwm_out(out_w)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit w, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (w) wr_w = 1'b1; else wr_l = 1'b1;
    @(negedge clk);
    wr_w = 1'b0; wr_l = 1'b0;
  endtask

  task automatic rd(input bit w, input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    if (w) rd_w = 1'b1; else rd_l = 1'b1;
    @(negedge clk);
    rd_w = 1'b0; rd_l = 1'b0;
    v = w ? rdata_w : rdata_l;
  endtask

  task automatic measure(input bit w, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (w ? out_w : out_l) hi++;
      @(negedge clk);
    end
  endtask

  function automatic logic cur(input bit w);
    return w ? out_w : out_l;
  endfunction

  // R1
  task automatic t_reset();
    logic [31:0] v;
    check(out_l == 1'b0 && out_w == 1'b0, "R1", "outputs after reset", {out_l, out_w}, 0);
    rd(1'b0, 4'h0, v); check(v == 32'h0, "R1", "compact reg0", v, 0);
    rd(1'b1, 4'h0, v); check(v == 32'h0, "R1", "wide reg0", v, 0);
    rd(1'b1, 4'h4, v); check(v == 32'h0, "R1", "wide reg1", v, 0);
  endtask

  // R2 R10
  task automatic t_compact_regs();
    logic [31:0] v;
    wr(1'b0, 4'h0, 32'hFFFF_FFFF);
    rd(1'b0, 4'h0, v); check(v == 32'h81FF_1FFF, "R2", "compact reg0 mask", v, 32'h81FF_1FFF);
    check(rdata_l == 32'h81FF_1FFF, "R10", "rdata held after read", rdata_l, 32'h81FF_1FFF);
    wr(1'b0, 4'h4, 32'hFFFF_FFFF);
    rd(1'b0, 4'h4, v); check(v == 32'h0, "R2", "compact addr 4", v, 0);
    wr(1'b0, 4'h0, 32'h0);
  endtask

  // R3
  task automatic t_wide_regs();
    logic [31:0] v;
    wr(1'b1, 4'h0, 32'hFFFF_FFFF);
    rd(1'b1, 4'h0, v); check(v == 32'hFFFF_FFFF, "R3", "wide reg0", v, 32'hFFFF_FFFF);
    wr(1'b1, 4'h4, 32'hFFFF_FFFF);
    rd(1'b1, 4'h4, v); check(v == 32'hFFFF_8000, "R3", "wide reg1 mask", v, 32'hFFFF_8000);
    wr(1'b1, 4'h8, 32'h1234_5678);
    rd(1'b1, 4'h8, v); check(v == 32'h0, "R3", "unmapped addr", v, 0);
    wr(1'b1, 4'h4, 32'h0);
    wr(1'b1, 4'h0, 32'h0);
  endtask

  // R4 compact: duty 128, scale 1 -> period 512, high 256; then duty 255 scale 0
  task automatic t_compact_duty();
    int hi;
    wr(1'b0, 4'h0, 32'h8080_0001);
    @(negedge clk);
    measure(1'b0, 512, hi); check(hi == 256, "R4", "compact duty 128 high cycles", hi, 256);
    check(cur(1'b0) == 1'b1, "R4", "next period starts high", cur(1'b0), 1);
    wr(1'b0, 4'h0, 32'h0);
    wr(1'b0, 4'h0, 32'h80FF_0000);
    @(negedge clk);
    measure(1'b0, 256, hi); check(hi == 255, "R4", "compact duty 255 high cycles", hi, 255);
    wr(1'b0, 4'h0, 32'h0);
  endtask

  // R5
  task automatic t_zero();
    int hi;
    wr(1'b0, 4'h0, 32'h8000_0000);
    @(negedge clk);
    measure(1'b0, 256, hi); check(hi == 0, "R5", "compact duty 0", hi, 0);
    wr(1'b0, 4'h0, 32'h0);
    wr(1'b1, 4'h0, 32'h0000_0001);
    wr(1'b1, 4'h4, 32'h8000_0000 | (32'd9 << 15));
    @(negedge clk);
    measure(1'b1, 40, hi); check(hi == 0, "R5", "wide duty 0", hi, 0);
    wr(1'b1, 4'h4, 32'h0);
  endtask

  // R6
  task automatic t_force();
    int hi;
    wr(1'b0, 4'h0, 32'h8105_0000);
    @(negedge clk);
    measure(1'b0, 256, hi); check(hi == 256, "R6", "force-full bit", hi, 256);
    wr(1'b0, 4'h0, 32'h0);
  endtask

  // R4 R7 wide: depth 9 scale 1 -> period 20
  task automatic t_wide_duty();
    int hi;
    wr(1'b1, 4'h0, (32'd3 << 16) | 32'd1);
    wr(1'b1, 4'h4, 32'h8000_0000 | (32'd9 << 15));
    @(negedge clk);
    measure(1'b1, 20, hi); check(hi == 6, "R4", "wide duty 3 high cycles", hi, 6);
    check(cur(1'b1) == 1'b1, "R4", "wide next period starts high", cur(1'b1), 1);
    wr(1'b1, 4'h4, 32'h0);
    wr(1'b1, 4'h0, (32'd10 << 16) | 32'd1);
    wr(1'b1, 4'h4, 32'h8000_0000 | (32'd9 << 15));
    @(negedge clk);
    measure(1'b1, 20, hi); check(hi == 20, "R7", "wide duty = depth+1", hi, 20);
    wr(1'b1, 4'h4, 32'h0);
    wr(1'b1, 4'h0, 32'hFFFF_0001);
    wr(1'b1, 4'h4, 32'h8000_0000 | (32'd9 << 15));
    @(negedge clk);
    measure(1'b1, 20, hi); check(hi == 20, "R7", "wide duty max", hi, 20);
  endtask

  // R8 (block still running from t_wide_duty at full duty)
  task automatic t_disable_restart();
    int hi;
    wr(1'b1, 4'h4, 32'h0);
    @(negedge clk);
    check(cur(1'b1) == 1'b0, "R8", "low two edges after disable", cur(1'b1), 0);
    measure(1'b1, 40, hi); check(hi == 0, "R8", "stays low while disabled", hi, 0);
    wr(1'b1, 4'h0, (32'd3 << 16) | 32'd1);
    wr(1'b1, 4'h4, 32'h8000_0000 | (32'd9 << 15));
    repeat (8) @(negedge clk);
    wr(1'b1, 4'h4, 32'h0);
    wr(1'b1, 4'h4, 32'h8000_0000 | (32'd9 << 15));
    @(negedge clk);
    measure(1'b1, 6, hi); check(hi == 6, "R8", "restart from count zero", hi, 6);
    check(cur(1'b1) == 1'b0, "R8", "low after restart high time", cur(1'b1), 0);
    wr(1'b1, 4'h4, 32'h0);
  endtask

  // R9: duty 3 -> 7 written at period index 1
  task automatic t_boundary();
    int hi;
    wr(1'b1, 4'h0, (32'd3 << 16) | 32'd1);
    wr(1'b1, 4'h4, 32'h8000_0000 | (32'd9 << 15));
    @(negedge clk);
    wr(1'b1, 4'h0, (32'd7 << 16) | 32'd1);
    measure(1'b1, 18, hi); check(hi == 4, "R9", "old duty kept to period end", hi, 4);
    measure(1'b1, 20, hi); check(hi == 14, "R9", "new duty next period", hi, 14);
    wr(1'b1, 4'h4, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_compact_regs();
    t_wide_regs();
    t_compact_duty();
    t_zero();
    t_force();
    t_wide_duty();
    t_disable_restart();
    t_boundary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1..: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule